// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block sits behind a CAN protocol engine. Once a frame has been fully assembled, the engine presents the frame's identifier and its format flag, and pulses a strobe. The block then decides whether the frame is kept and which of two receive buffers it goes to. Six programmable filters, each carrying its own format bit, are compared against the identifier through two programmable masks. Filters 0 and 1 share one mask and feed buffer 0. Filters 2 to 5 share the other mask and feed buffer 1.

The comparison itself is combinational. The accept flag, the buffer select and the number of the filter that hit are captured on the edge that samples the strobe, and they stay unchanged until the next strobe. A frame that no filter takes is simply dropped, with all three outputs cleared. Bit-level reception, CRC checking and buffer storage are handled elsewhere.

Top module: `can_accept_filter`

## Requirements
- R1: Six filters are provided. A hit on filter 0 or 1 gives `buf_sel_o`=0, and a hit on filters 2 to 5 gives `buf_sel_o`=1. `hit_idx_o` carries the winning filter's number in binary.
- R2: Filters 0 and 1 are compared through `mask0_i` only, and filters 2 to 5 through `mask1_i` only.
- R3: A mask bit of 0 makes that identifier bit a don't-care. A mask bit of 1 requires the identifier bit to equal the filter bit.
- R4: A frame with `frame_ext_i`=0 is compared only against filters whose `flt_ext_i` bit is 0, and only over bits [10:0] of the identifier, filter and mask.
- R5: A frame with `frame_ext_i`=1 is compared only against filters whose `flt_ext_i` bit is 1, over all 29 identifier bits.
- R6: When several filters match, the lowest-numbered one is reported, so a buffer-0 hit always beats a buffer-1 hit.
- R7: When no filter matches, `accept_o`=0, `buf_sel_o`=0 and `hit_idx_o`=0, and no other indication is given.
- R8: The outputs take the result on the clock edge that samples `frame_vld_i` high. They hold while `frame_vld_i` is low, whatever the other inputs do.
- R9: After reset, `accept_o`, `buf_sel_o` and `hit_idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_vld_i | input | 1 | Strobe: an assembled frame is present |
| frame_id_i | input | 29 | Frame identifier; standard frames use bits [10:0] |
| frame_ext_i | input | 1 | 1 = extended frame, 0 = standard frame |
| flt_id_i | input | 6x29 | Filter values, one per filter |
| flt_ext_i | input | 6 | Per-filter format bit |
| mask0_i | input | 29 | Mask for filters 0 and 1 |
| mask1_i | input | 29 | Mask for filters 2 to 5 |
| accept_o | output | 1 | Frame accepted |
| buf_sel_o | output | 1 | Target receive buffer |
| hit_idx_o | output | 3 | Number of the winning filter |

## Verification
The bench targets the following faults and how each would show up:
- **Upper identifier bits on a standard frame.** A design that compares bits [28:11] would reject frames that should pass.
- **Format bit ignored.** A design that ignores the filter's format bit would let a standard-configured filter catch an extended frame.
- **Wrong priority.** Several filters can match at once. Any priority other than lowest-number-first would report a buffer-1 filter when filter 1 also hit.
- **Crossed masks.** With one mask all zeros and the other all ones, a design that mixed up the masks would accept or reject the wrong frames.
- **Outputs not held.** Changing the inputs while the strobe is low exposes outputs that follow the inputs instead of holding.

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int ID_W     = 29,
  parameter int STD_W    = 11,
  parameter int NUM_FILT = 6,
  parameter int BUF0_CNT = 2,
  localparam int IDX_W   = $clog2(NUM_FILT)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           frame_vld_i,
  input  logic [ID_W-1:0]                frame_id_i,
  input  logic                           frame_ext_i,
  input  logic [NUM_FILT-1:0][ID_W-1:0]  flt_id_i,
  input  logic [NUM_FILT-1:0]            flt_ext_i,
  input  logic [ID_W-1:0]                mask0_i,
  input  logic [ID_W-1:0]                mask1_i,
  output logic                           accept_o,
  output logic                           buf_sel_o,
  output logic [IDX_W-1:0]               hit_idx_o
);

  localparam logic [ID_W-1:0] STD_SPAN = ID_W'((64'd1 << STD_W) - 64'd1);

  logic [ID_W-1:0]     span;
  logic [NUM_FILT-1:0] hit;
  logic [IDX_W-1:0]    win;

  assign span = frame_ext_i ? '1 : STD_SPAN;

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_flt
    logic [ID_W-1:0] msk;
    assign msk    = (g < BUF0_CNT) ? mask0_i : mask1_i;
    assign hit[g] = (flt_ext_i[g] == frame_ext_i) &&
                    (((frame_id_i ^ flt_id_i[g]) & msk & span) == '0);
  end

  always_comb begin
    win = '0;
    for (int i = NUM_FILT - 1; i >= 0; i--)
      if (hit[i]) win = IDX_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o  <= 1'b0;
      buf_sel_o <= 1'b0;
      hit_idx_o <= '0;
    end else if (frame_vld_i) begin
      accept_o  <= |hit;
      buf_sel_o <= (|hit) && (32'(win) >= BUF0_CNT);
      hit_idx_o <= (|hit) ? win : '0;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> $stable({accept_o, buf_sel_o, hit_idx_o}));

  p_idx_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (32'(hit_idx_o) < NUM_FILT));

  p_buf_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (buf_sel_o == (32'(hit_idx_o) >= BUF0_CNT)));

  p_fmt_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i |=> (!accept_o || (flt_ext_i[hit_idx_o] == $past(frame_ext_i))));

  p_reject_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> (!buf_sel_o && hit_idx_o == '0));

endmodule

// File: tb/can_accept_filter_tb_top.sv
`timescale 1ns/1ps
module can_accept_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_vld = 1'b0;
  logic [28:0] f_id = '0;
  logic f_ext = 1'b0;
  logic [5:0][28:0] fid = '0;
  logic [5:0] fe = '0;
  logic [28:0] mk0 = '0, mk1 = '0;
  logic accept_o, buf_sel_o;
  logic [2:0] hit_idx_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  can_accept_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_vld_i(frame_vld),
    .frame_id_i(f_id), .frame_ext_i(f_ext), .flt_id_i(fid), .flt_ext_i(fe),
    .mask0_i(mk0), .mask1_i(mk1),
    .accept_o(accept_o), .buf_sel_o(buf_sel_o), .hit_idx_o(hit_idx_o));

  function automatic logic [4:0] model();
    logic [28:0] cm, m;
    cm = f_ext ? '1 : 29'h7FF;
    for (int i = 0; i < 6; i++) begin
      m = (i < 2) ? mk0 : mk1;
      if (fe[i] == f_ext && (((f_id ^ fid[i]) & m & cm) == '0))
        return {1'b1, (i >= 2), 3'(i)};
    end
    return 5'b0;
  endfunction

  task automatic check(input string tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {accept_o, buf_sel_o, hit_idx_o};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got acc/buf/idx=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic run_frame(input string tag, input logic [4:0] exp);
    @(negedge clk); frame_vld = 1'b1;
    @(negedge clk); frame_vld = 1'b0;
    check(tag, exp);
    @(negedge clk);
  endtask

  task automatic all_miss();
    for (int i = 0; i < 6; i++) begin fid[i] = ~f_id; fe[i] = f_ext; end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] held;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R9 reset", 5'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: zero mask accepts any identifier
    f_ext = 0; f_id = 29'h155; all_miss(); mk0 = '0; mk1 = '1;
    run_frame("R3 zero mask", {1'b1, 1'b0, 3'd0});

    // R4: standard frame ignores bits above 10
    mk0 = '1; all_miss(); fid[1] = f_id ^ 29'h1FFF_F800;
    run_frame("R4 upper bits", {1'b1, 1'b0, 3'd1});

    // R5/R7: extended frame skips standard filters
    f_ext = 1; f_id = 29'h0ABC_DEF1; all_miss();
    for (int i = 0; i < 6; i++) begin fid[i] = f_id; fe[i] = 1'b0; end
    run_frame("R5 R7 fmt gate", 5'b0);
    fe[3] = 1'b1;
    run_frame("R5 R1 ext hit", {1'b1, 1'b1, 3'd3});

    // R3/R5: bit 20 masked in or out
    all_miss(); fid[4] = f_id ^ 29'h0010_0000; mk1 = '1;
    run_frame("R3 mask bit set", 5'b0);
    mk1 = ~29'h0010_0000;
    run_frame("R3 mask bit clear", {1'b1, 1'b1, 3'd4});

    // R6: priority
    mk0 = '1; mk1 = '1; all_miss(); fid[1] = f_id; fid[2] = f_id; fid[4] = f_id;
    run_frame("R6 lowest wins", {1'b1, 1'b0, 3'd1});
    fid[1] = ~f_id;
    run_frame("R6 buf1 lowest", {1'b1, 1'b1, 3'd2});

    // R2: masks bound to their filter groups
    f_ext = 0; f_id = 29'h3A5; all_miss(); mk0 = '0; mk1 = '1;
    fe[0] = 1'b1; fe[1] = 1'b1;
    run_frame("R2 mask1 strict", 5'b0);
    fe[5] = 1'b0; fid[5] = f_id;
    run_frame("R2 mask1 exact", {1'b1, 1'b1, 3'd5});

    // R8: hold while strobe low
    held = {accept_o, buf_sel_o, hit_idx_o};
    f_id = ~f_id; mk0 = '0; fe = '0; f_ext = 0;
    repeat (3) @(negedge clk);
    check("R8 hold", held);
    @(negedge clk);

    // random
    for (int k = 0; k < 400; k++) begin
      f_ext = 1'($urandom);
      f_id  = 29'($urandom);
      for (int i = 0; i < 6; i++) begin
        fid[i] = f_id ^ 29'($urandom & $urandom & $urandom & $urandom);
        fe[i]  = ($urandom % 4) != 0 ? f_ext : ~f_ext;
      end
      mk0 = 29'($urandom | $urandom);
      mk1 = 29'($urandom | $urandom);
      run_frame("R1 R6 random", model());
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule